// File: doc/BRIEF.md
# Sensor Readout Window and Sub-Sampler

This block is the readout timing generator for a Bayer-pattern image sensor. It derives a pixel-period enable from the system clock and scans the physical array one pixel per period. For each scan position it produces a line strobe, a frame strobe and a pixel qualifier, and it reports the current row and column so that the caller can fetch or tag the pixel data. The array defaults to 644 columns by 488 rows. The first rows of the array are dark reference rows (4 by default), and the remaining 484 rows are active.

A rectangular window of interest is programmed as a start column and a start row, plus a column span and a row span. Each span holds the pixel count minus one. The window can be any size from 20x14 up to the full array, at any position. Inside the window the output can be decimated to one half or one quarter in each direction. Decimation keeps whole pairs of adjacent columns and adjacent rows, so every 2x2 colour cell stays intact. Each line has a blanking tail that is programmed in units of two pixel periods. The number of lines per frame is programmable, and a control bit decides whether the dark rows are shown or hidden. All configuration passes through a shadow stage that is loaded only at a frame start.

The scan controller has three states. ST_LOAD is the state after reset. ST_ACTIVE walks the window columns of a line. ST_BLANK counts the blanking tail. The transitions are:
- LOAD_TO_ACTIVE: first pixel period; the shadow is loaded and line 0 starts.
- ACTIVE_STEP: the next column.
- ACTIVE_TO_BLANK: the last window column, when the blanking field is non-zero.
- ACTIVE_NEXT_LINE: the last window column, when the blanking field is zero.
- BLANK_STEP: the next blanking period.
- BLANK_NEXT_LINE: the last blanking period.
- FRAME_WRAP: a line end on the last line of the frame. It returns to line 0 and reloads the shadow.

Top module: `sensor_readout_timer`

## Requirements
- R1: `pix_en` is high for exactly one system clock in every DIV clocks (DIV defaults to 4). After reset release it is first high in the DIV-th clock cycle, and then every DIV cycles. Scan position and outputs change only at the clock edge that ends a cycle in which `pix_en` was high.
- R2: During reset and in the first pixel period after it (ST_LOAD), `hsync`, `vsync` and `pix_valid` are low and `row_idx` and `col_idx` are zero.
- R3: Each line lasts `cfg_col_span`+1 window pixel periods followed by 2*`cfg_hblank` blanking periods. A blanking value of 0 gives a line with no blanking.
- R4: A frame lasts `cfg_frame_lines`+1 lines (line index 0 upwards). `vsync` is high for the whole of line 0, and `row_idx` gives the line index.
- R5: A line is valid when all of the following hold: its index lies within `cfg_row_start` .. `cfg_row_start`+`cfg_row_span`; the index is below the array row count; the line is not masked as dark; and vertical decimation keeps it. `hsync` is high exactly during the window pixel periods of a valid line.
- R6: Lines 0 .. DARK_ROWS-1 are dark rows. They are hidden when `cfg_show_dark` is 0 and may be valid when it is 1.
- R7: `pix_valid` is `hsync` qualified by horizontal decimation. `col_idx` equals `cfg_col_start` plus the column offset within the window, wrapping at the column-field width.
- R8: `cfg_decim` selects the decimation mode by offset within the window:
  - 0 keeps every column and row.
  - 1 keeps the offsets whose bit 1 is 0, so pairs are kept and pairs skipped.
  - 2 and 3 keep the offsets whose bits [2:1] are 0, so one pair is kept out of four.
  - The same rule applies to column offsets and to row offsets (line index minus `cfg_row_start`).
- R9: Every `cfg_*` input is sampled only in the LOAD_TO_ACTIVE and FRAME_WRAP transitions. A change made mid-frame has no effect on the outputs until the next frame starts.
- R10: The smallest window (20 columns by 14 rows) and a window that covers the full array both scan correctly when placed at non-zero offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_col_start | input | HW=$clog2(COLS) | First window column |
| cfg_row_start | input | VW=$clog2(ROWS) | First window row |
| cfg_col_span | input | HW | Window width minus one |
| cfg_row_span | input | VW | Window height minus one |
| cfg_hblank | input | 8 | Line blanking in units of two pixel periods |
| cfg_frame_lines | input | LW=VW+1 | Lines per frame minus one |
| cfg_show_dark | input | 1 | 1 shows dark rows, 0 hides them |
| cfg_decim | input | 2 | Decimation: 0 full, 1 half, 2/3 quarter |
| pix_en | output | 1 | Pixel-period enable, one clock per period |
| hsync | output | 1 | High over the window span of a valid line |
| vsync | output | 1 | High during line 0 of each frame |
| pix_valid | output | 1 | Current pixel is delivered |
| row_idx | output | LW | Current line index |
| col_idx | output | HW | Current array column |

## Verification
The bench targets these corner cases:
- A blanking field of zero. A design that always inserted at least one blanking period would stretch every line and drift out of step within the first line.
- Windows that run past the array rows or into the dark rows with masking on. A wrong row test shows up as `hsync` on lines that must stay quiet.
- Both decimation modes at odd start offsets. A design that dropped single pixels instead of pairs would break the pair pattern of `pix_valid`.
- Configuration rewritten in the middle of a frame. A design without the shadow stage would change its line length or window within the same frame.

// File: rtl/sensor_readout_pkg.sv
package sensor_readout_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_BLANK  = 2'd2
    } scan_state_e;

    typedef enum logic [1:0] {
        DEC_FULL    = 2'd0,
        DEC_HALF    = 2'd1,
        DEC_QUARTER = 2'd2,
        DEC_QUART_B = 2'd3
    } decim_mode_e;

    // pair_bits holds offset bits [2:1]; bit 0 selects inside a kept pair
    function automatic logic pair_kept(input logic [1:0] pair_bits,
                                       input logic [1:0] mode);
        logic keep;
        unique case (decim_mode_e'(mode))
            DEC_FULL:    keep = 1'b1;
            DEC_HALF:    keep = ~pair_bits[0];
            DEC_QUARTER,
            DEC_QUART_B: keep = (pair_bits == 2'b00);
            default:     keep = 1'b1;
        endcase
        return keep;
    endfunction

endpackage

// File: rtl/readout_pixdiv.sv
module readout_pixdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic pix_en
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pix_en = (cnt == LAST);

endmodule

// File: rtl/readout_shadow.sv
module readout_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/readout_scan.sv
module readout_scan
    import sensor_readout_pkg::*;
#(
    parameter int HW = 10,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic [HW-1:0] col_span,
    input  logic [7:0]    hblank,
    input  logic [LW-1:0] frame_lines,
    output scan_state_e   st,
    output logic [HW-1:0] x,
    output logic [LW-1:0] y,
    output logic          frame_load
);
    scan_state_e   st_n;
    logic [HW-1:0] x_n;
    logic [LW-1:0] y_n;
    logic [8:0]    bc, bc_n;
    logic [8:0]    blank_last;
    logic          line_end;

    assign blank_last = {hblank, 1'b0} - 9'd1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_LOAD;
            x  <= '0;
            y  <= '0;
            bc <= '0;
        end else begin
            st <= st_n;
            x  <= x_n;
            y  <= y_n;
            bc <= bc_n;
        end
    end

    // next state
    always_comb begin
        st_n       = st;
        x_n        = x;
        y_n        = y;
        bc_n       = bc;
        frame_load = 1'b0;
        line_end   = 1'b0;
        if (pix_en) begin
            unique case (st)
                ST_LOAD: begin                      // LOAD_TO_ACTIVE
                    st_n       = ST_ACTIVE;
                    x_n        = '0;
                    y_n        = '0;
                    frame_load = 1'b1;
                end
                ST_ACTIVE: begin
                    if (x == col_span) begin
                        if (hblank == 8'd0) begin   // ACTIVE_NEXT_LINE
                            line_end = 1'b1;
                        end else begin              // ACTIVE_TO_BLANK
                            st_n = ST_BLANK;
                            bc_n = '0;
                        end
                    end else begin                  // ACTIVE_STEP
                        x_n = x + 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (bc == blank_last) begin     // BLANK_NEXT_LINE
                        line_end = 1'b1;
                    end else begin                  // BLANK_STEP
                        bc_n = bc + 9'd1;
                    end
                end
                default: st_n = ST_LOAD;
            endcase
            if (line_end) begin
                st_n = ST_ACTIVE;
                x_n  = '0;
                if (y == frame_lines) begin         // FRAME_WRAP
                    y_n        = '0;
                    frame_load = 1'b1;
                end else begin
                    y_n = y + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/readout_qual.sv
module readout_qual
    import sensor_readout_pkg::*;
#(
    parameter int HW        = 10,
    parameter int VW        = 9,
    parameter int LW        = 10,
    parameter int ROWS      = 488,
    parameter int DARK_ROWS = 4
) (
    input  scan_state_e   st,
    input  logic [HW-1:0] x,
    input  logic [LW-1:0] y,
    input  logic [HW-1:0] col_start,
    input  logic [VW-1:0] row_start,
    input  logic [VW-1:0] row_span,
    input  logic          show_dark,
    input  logic [1:0]    decim,
    output logic          hsync,
    output logic          vsync,
    output logic          pix_valid,
    output logic [LW-1:0] row_idx,
    output logic [LW-1:0] row_off,
    output logic [HW-1:0] col_idx
);
    localparam logic [LW-1:0] ROW_LIMIT = LW'(ROWS);
    localparam logic [LW-1:0] DARK_LIM  = LW'(DARK_ROWS);

    logic [LW-1:0] rs_ext, rspan_ext;
    logic          in_scan, row_in, row_keep, col_keep;

    assign rs_ext    = {1'b0, row_start};
    assign rspan_ext = {1'b0, row_span};
    assign row_off   = y - rs_ext;

    // outputs
    always_comb begin
        in_scan  = (st != ST_LOAD);
        row_in   = in_scan && (y >= rs_ext) && (row_off <= rspan_ext)
                   && (y < ROW_LIMIT) && (show_dark || (y >= DARK_LIM));
        row_keep = pair_kept(row_off[2:1], decim);
        col_keep = pair_kept(x[2:1], decim);
        vsync     = in_scan && (y == '0);
        hsync     = (st == ST_ACTIVE) && row_in && row_keep;
        pix_valid = hsync && col_keep;
        row_idx   = y;
        col_idx   = col_start + x;
    end

endmodule

// File: rtl/sensor_readout_timer.sv
module sensor_readout_timer
    import sensor_readout_pkg::*;
#(
    parameter int COLS      = 644,
    parameter int ROWS      = 488,
    parameter int DARK_ROWS = 4,
    parameter int DIV       = 4,
    localparam int HW       = $clog2(COLS),
    localparam int VW       = $clog2(ROWS),
    localparam int LW       = VW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] cfg_col_start,
    input  logic [VW-1:0] cfg_row_start,
    input  logic [HW-1:0] cfg_col_span,
    input  logic [VW-1:0] cfg_row_span,
    input  logic [7:0]    cfg_hblank,
    input  logic [LW-1:0] cfg_frame_lines,
    input  logic          cfg_show_dark,
    input  logic [1:0]    cfg_decim,
    output logic          pix_en,
    output logic          hsync,
    output logic          vsync,
    output logic          pix_valid,
    output logic [LW-1:0] row_idx,
    output logic [HW-1:0] col_idx
);
    localparam int SW = 2 * HW + 2 * VW + 8 + LW + 1 + 2;

    logic [HW-1:0] sh_col_start, sh_col_span;
    logic [VW-1:0] sh_row_start, sh_row_span;
    logic [7:0]    sh_hblank;
    logic [LW-1:0] sh_frame_lines;
    logic          sh_show_dark;
    logic [1:0]    sh_decim;
    logic          frame_load;
    scan_state_e   st;
    logic [HW-1:0] x;
    logic [LW-1:0] y;
    logic [LW-1:0] row_off;

    readout_pixdiv #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_en (pix_en)
    );

    readout_shadow #(.W(SW)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_load),
        .d     ({cfg_col_start, cfg_row_start, cfg_col_span, cfg_row_span,
                 cfg_hblank, cfg_frame_lines, cfg_show_dark, cfg_decim}),
        .q     ({sh_col_start, sh_row_start, sh_col_span, sh_row_span,
                 sh_hblank, sh_frame_lines, sh_show_dark, sh_decim})
    );

    readout_scan #(.HW(HW), .LW(LW)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en      (pix_en),
        .col_span    (sh_col_span),
        .hblank      (sh_hblank),
        .frame_lines (sh_frame_lines),
        .st          (st),
        .x           (x),
        .y           (y),
        .frame_load  (frame_load)
    );

    readout_qual #(
        .HW(HW), .VW(VW), .LW(LW), .ROWS(ROWS), .DARK_ROWS(DARK_ROWS)
    ) u_qual (
        .st        (st),
        .x         (x),
        .y         (y),
        .col_start (sh_col_start),
        .row_start (sh_row_start),
        .row_span  (sh_row_span),
        .show_dark (sh_show_dark),
        .decim     (sh_decim),
        .hsync     (hsync),
        .vsync     (vsync),
        .pix_valid (pix_valid),
        .row_idx   (row_idx),
        .row_off   (row_off),
        .col_idx   (col_idx)
    );

endmodule

// File: rtl/sensor_readout_checker.sv
module sensor_readout_checker #(
    parameter int HW        = 10,
    parameter int LW        = 10,
    parameter int DARK_ROWS = 4,
    parameter int DIV       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          hsync,
    input logic          vsync,
    input logic          pix_valid,
    input logic [LW-1:0] row_idx,
    input logic [HW-1:0] col_idx,
    input logic [HW-1:0] sh_col_start,
    input logic [HW-1:0] sh_col_span,
    input logic          sh_show_dark,
    input logic [1:0]    sh_decim
);
    int            gap;
    logic          seen;
    logic [HW-1:0] col_off;

    assign col_off = col_idx - sh_col_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (pix_en) begin
            gap  <= 0;
            seen <= 1'b1;
        end else begin
            gap <= gap + 1;
        end
    end

    AST_PIXEN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && seen) |-> (gap == DIV - 1)); // R1

    AST_PIXEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en); // R1

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(row_idx) && $stable(col_idx) && $stable(hsync))); // R1

    AST_VSYNC_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (row_idx == '0)); // R4

    AST_VALID_UNDER_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> hsync); // R7

    AST_COL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (col_off <= sh_col_span)); // R7

    AST_DARK_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && !sh_show_dark) |-> (row_idx >= LW'(DARK_ROWS))); // R6

    AST_QUARTER_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && sh_decim[1]) |-> (col_off[2:1] == 2'b00)); // R8

    AST_HALF_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (sh_decim == 2'd1)) |-> !col_off[1]); // R8

endmodule

bind sensor_readout_timer sensor_readout_checker #(
    .HW(HW), .LW(LW), .DARK_ROWS(DARK_ROWS), .DIV(DIV)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_en       (pix_en),
    .hsync        (hsync),
    .vsync        (vsync),
    .pix_valid    (pix_valid),
    .row_idx      (row_idx),
    .col_idx      (col_idx),
    .sh_col_start (sh_col_start),
    .sh_col_span  (sh_col_span),
    .sh_show_dark (sh_show_dark),
    .sh_decim     (sh_decim)
);

// File: tb/sensor_readout_timer_test.sv
`timescale 1ns/1ps
module sensor_readout_timer_test;
    localparam int COLS = 24;
    localparam int ROWS = 16;
    localparam int DARK = 2;
    localparam int DIV  = 4;
    localparam int HW   = $clog2(COLS);
    localparam int VW   = $clog2(ROWS);
    localparam int LW   = VW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] cfg_col_start, cfg_col_span;
    logic [VW-1:0] cfg_row_start, cfg_row_span;
    logic [7:0]    cfg_hblank;
    logic [LW-1:0] cfg_frame_lines;
    logic          cfg_show_dark;
    logic [1:0]    cfg_decim;
    logic          pix_en, hsync, vsync, pix_valid;
    logic [LW-1:0] row_idx;
    logic [HW-1:0] col_idx;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R2";

    always #5 clk = ~clk;

    sensor_readout_timer #(
        .COLS(COLS), .ROWS(ROWS), .DARK_ROWS(DARK), .DIV(DIV)
    ) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, tag, $time, act, exp);
        end
    endtask

    function automatic bit kept(input int off, input int mode);
        if (mode == 0) return 1'b1;
        if (mode == 1) return ((off / 2) % 2) == 0;
        return ((off / 2) % 4) == 0;
    endfunction

    // behavioural reference: position derived from elapsed pixel periods
    int m_cs, m_rs, m_cspan, m_rspan, m_hb, m_fl, m_show, m_dec;
    int e, g, f0, len, tot, nframes;
    bit frame_evt;
    bit x_en, x_hs, x_vs, x_valid;
    int x_row, x_col;

    always @(posedge clk) begin
        if (!rst_n) begin
            e = 0; g = 0; f0 = 0; nframes = 0; frame_evt = 0;
            x_en = 0; x_hs = 0; x_vs = 0; x_valid = 0; x_row = 0; x_col = 0;
        end else begin
            e = e + 1;
            if (e >= DIV && ((e - DIV) % DIV) == 0) begin
                g = (e - DIV) / DIV;
                if (g == 0 || g - f0 == tot) begin
                    frame_evt = (g != 0);
                    f0 = g;
                    m_cs = int'(cfg_col_start); m_rs = int'(cfg_row_start);
                    m_cspan = int'(cfg_col_span); m_rspan = int'(cfg_row_span);
                    m_hb = int'(cfg_hblank); m_fl = int'(cfg_frame_lines);
                    m_show = int'(cfg_show_dark); m_dec = int'(cfg_decim);
                    len = m_cspan + 1 + 2 * m_hb;
                    tot = (m_fl + 1) * len;
                    nframes++;
                end
            end
            x_en = (e % DIV) == DIV - 1;
            if (e < DIV) begin
                x_hs = 0; x_vs = 0; x_valid = 0; x_row = 0; x_col = 0;
            end else begin
                int t, ln, pos;
                bit rowv;
                t   = g - f0;
                ln  = t / len;
                pos = t % len;
                rowv = (ln >= m_rs) && (ln - m_rs <= m_rspan) && (ln < ROWS)
                       && (m_show != 0 || ln >= DARK) && kept(ln - m_rs, m_dec);
                x_vs    = (ln == 0);
                x_hs    = (pos <= m_cspan) && rowv;
                x_valid = x_hs && kept(pos, m_dec);
                x_row   = ln;
                x_col   = (m_cs + pos) % (1 << HW);
            end
        end
    end

    // every-cycle comparison away from the active edge
    int dut_cnt = 0, mod_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (frame_evt) begin
                chk(dut_cnt == mod_cnt, "R5 R7 frame pixel count", dut_cnt, mod_cnt);
                dut_cnt = 0; mod_cnt = 0; frame_evt = 0;
            end
            chk(pix_en == x_en, "R1 pix_en", int'(pix_en), int'(x_en));
            chk(vsync == x_vs, "R4 vsync", int'(vsync), int'(x_vs));
            chk(hsync == x_hs, "R5 R3 hsync", int'(hsync), int'(x_hs));
            chk(pix_valid == x_valid, "R7 R8 pix_valid", int'(pix_valid), int'(x_valid));
            if (x_hs || e < DIV) begin
                chk(int'(row_idx) == x_row, "R4 row_idx", int'(row_idx), x_row);
                chk(int'(col_idx) == x_col, "R7 col_idx", int'(col_idx), x_col);
            end
            if (pix_en && pix_valid) dut_cnt++;
            if (x_en && x_valid) mod_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_cfg(input int cs, input int rs, input int cspan, input int rspan,
                           input int hb, input int fl, input int show, input int dec);
        @(negedge clk);
        cfg_col_start = HW'(cs); cfg_row_start = VW'(rs);
        cfg_col_span = HW'(cspan); cfg_row_span = VW'(rspan);
        cfg_hblank = 8'(hb); cfg_frame_lines = LW'(fl);
        cfg_show_dark = show[0]; cfg_decim = 2'(dec);
    endtask

    task automatic wait_frames(input int n);
        int start;
        start = nframes;
        while (nframes < start + n) @(posedge clk);
    endtask

    initial begin
        cfg_col_start = '0; cfg_row_start = '0; cfg_col_span = HW'(COLS - 1);
        cfg_row_span = VW'(ROWS - 1); cfg_hblank = 8'd3; cfg_frame_lines = LW'(ROWS - 1);
        cfg_show_dark = 1'b1; cfg_decim = 2'd0;
        // R2: reset state
        repeat (3) @(negedge clk);
        chk(hsync == 0 && vsync == 0 && pix_valid == 0, "R2 strobes in reset",
            int'({hsync, vsync, pix_valid}), 0);
        chk(row_idx == 0 && col_idx == 0, "R2 position in reset",
            int'(row_idx) + int'(col_idx), 0);
        chk(pix_en == 0, "R2 R1 pix_en in reset", int'(pix_en), 0);
        @(negedge clk) rst_n = 1'b1;

        tag = "R3 R4 R5 full";
        wait_frames(2);
        tag = "R6 dark hidden";
        set_cfg(0, 0, COLS - 1, ROWS - 1, 3, ROWS - 1, 0, 0);
        wait_frames(2);
        tag = "R10 R3 min window, no blanking";
        set_cfg(4, 2, 19, 13, 0, ROWS - 1, 1, 0);
        wait_frames(2);
        tag = "R8 half decimation, long frame";
        set_cfg(1, 3, 15, 11, 2, ROWS + 3, 1, 1);
        wait_frames(2);
        tag = "R8 R6 quarter decimation";
        set_cfg(0, 0, COLS - 1, ROWS - 1, 1, ROWS - 1, 0, 2);
        wait_frames(2);
        tag = "R8 mode 3";
        set_cfg(3, 5, 20, 10, 4, ROWS - 1, 1, 3);
        wait_frames(2);
        tag = "R9 mid-frame rewrite";
        set_cfg(2, 1, 17, 12, 2, ROWS - 1, 1, 1);
        wait_frames(1);
        repeat (300) @(negedge clk);
        set_cfg(0, 0, 9, 5, 1, 9, 1, 0);
        repeat (300) @(negedge clk);
        set_cfg(5, 4, 18, 9, 0, ROWS - 1, 0, 2);
        wait_frames(3);
        tag = "R10 full window at offset";
        set_cfg(0, 2, COLS - 1, ROWS - 3, 2, ROWS - 1, 1, 0);
        wait_frames(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule